// File: doc/BRIEF.md
# Framer Interrupt Mask and Vector Unit

This unit sits beside an E1 receive framer and turns its alarm, timing and code-detect indications into a single interrupt request for a host. Each of eight sources has its own enable bit in a mask register. An unmasked event sets a pending flag for the group the source belongs to, and the unit presents an 8-bit vector that tells the host which group needs service.

There are three groups. The first holds the four sync and alarm levels: multiframe sync lost, CRC-4 multiframe sync lost, remote CRC failure (declared upstream from received E-bit error counts) and remote multiframe alarm. Each of these interrupts once on its rising edge. The second group is the one-second status level, which interrupts on every change in either direction. The third holds the three code-detect results (data match, start condition, stop condition). Each of these arrives as a pulse already qualified by its upstream enables, and each cycle it is high counts as an event. The host reads the vector and pulses an acknowledge. The acknowledge clears only the group being presented, so any other pending group then takes over the vector.

Top module: `frm_irq_vector`

## Requirements
- R1: During and immediately after reset, `irqReq` is 0, `irqVector` is 8'h00 and all eight mask bits are 0.
- R2: Mask bit layout: bits 3:0 enable the sync-group sources (bit 0 multiframe sync loss, 1 CRC-4 multiframe sync loss, 2 remote CRC failure, 3 remote multiframe alarm), bit 4 enables the one-second source, and bits 7:5 enable the code sources (5 data, 6 start, 7 stop). A source raises nothing while its bit is 0 and may raise an interrupt while its bit is 1.
- R3: A sync-group level (`syncLevel` bit i, using the same numbering as the mask) interrupts only on a 0-to-1 change. A level held high produces one interrupt, and a falling level produces none. The group reports vector 8'h80.
- R4: Any change of `secStatus`, rising or falling, interrupts with vector 8'h08. A steady level produces nothing.
- R5: Each cycle that `codeHit` bit 0 (data), 1 (start) or 2 (stop) is high counts as an event. The group reports vector 8'h02.
- R6: When several groups are pending, the vector is 8'h80 if the sync group is pending, otherwise 8'h08 if the one-second group is pending, otherwise 8'h02.
- R7: `irqReq` is 1 exactly while some group is pending. It stays 1 with no acknowledge, and `irqVector` is 8'h00 whenever `irqReq` is 0.
- R8: An acknowledge sampled at a clock edge clears only the group whose vector is shown in that cycle. The other pending groups are kept.
- R9: If an event of the acknowledged group arrives in the same cycle as the acknowledge, that group stays pending.
- R10: A mask write takes effect at the clock edge where it is sampled, so an edge in that same cycle still sees the old mask. An edge lost while its source was masked is not recovered by unmasking later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| maskWr | input | 1 | Mask register write strobe |
| maskData | input | 8 | Mask value to write |
| syncLevel | input | 4 | Sync and alarm status levels |
| secStatus | input | 1 | One-second status level |
| codeHit | input | 3 | Code-detect result pulses (data, start, stop) |
| ack | input | 1 | Host acknowledge of the presented vector |
| irqReq | output | 1 | Interrupt request, active high |
| irqVector | output | 8 | Vector of the highest-priority pending group |

## Verification
The bench holds a sync level high across an acknowledge. A design that detects levels instead of edges would re-raise the interrupt at once. It acknowledges while three groups are pending, to catch a clear that wipes every group or picks the wrong one. It also lands a code event on the same edge as the acknowledge of that group, where a clear-wins design would drop an interrupt. Finally, it writes the mask on the same edge as a sync edge and then unmasks over a level that is still high. A design that reads the new mask early, or that latches masked edges, would wrongly report 8'h80 there.

// File: rtl/frm_irq_pkg.sv
package frm_irq_pkg;

  // Group hits, from the datapath to the control
  typedef struct packed {
    logic sync;
    logic sec;
    logic code;
  } grpHit_t;

  // Vector selection strobes, from the control to the datapath
  typedef struct packed {
    logic selSync;
    logic selSec;
    logic selCode;
  } vecSel_t;

endpackage

// File: rtl/frm_irq_dp.sv
module frm_irq_dp
  import frm_irq_pkg::*;
#(
  parameter int NUM_SYNC = 4,
  parameter int NUM_CODE = 3,
  parameter int VEC_W = 8,
  parameter logic [VEC_W-1:0] SYNC_VEC = 8'h80,
  parameter logic [VEC_W-1:0] SEC_VEC = 8'h08,
  parameter logic [VEC_W-1:0] CODE_VEC = 8'h02
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       maskWr,
  input  logic [NUM_SYNC+NUM_CODE:0] maskData,
  input  logic [NUM_SYNC-1:0]        syncLevel,
  input  logic                       secStatus,
  input  logic [NUM_CODE-1:0]        codeHit,
  input  vecSel_t                    sel,
  output grpHit_t                    hit,
  output logic [VEC_W-1:0]           irqVector
);

  localparam int MASK_W = NUM_SYNC + NUM_CODE + 1;
  localparam int SEC_BIT = NUM_SYNC;
  localparam int CODE_BASE = NUM_SYNC + 1;

  logic [MASK_W-1:0]   maskReg;
  logic [NUM_SYNC-1:0] prevSync;
  logic                prevSec;
  logic                armed;
  logic [NUM_SYNC-1:0] syncRise;
  logic [NUM_CODE-1:0] codeFire;
  logic                secChange;

  // Mask register: every source starts blocked
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) maskReg <= '0;
    else if (maskWr) maskReg <= maskData;
  end

  // Level history for edge detection. The first cycle after reset only
  // captures a baseline, so levels present at release raise nothing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevSync <= '0;
      prevSec  <= 1'b0;
      armed    <= 1'b0;
    end else begin
      prevSync <= syncLevel;
      prevSec  <= secStatus;
      armed    <= 1'b1;
    end
  end

  for (genvar i = 0; i < NUM_SYNC; i++) begin : g_syncEdge
    assign syncRise[i] = armed & syncLevel[i] & ~prevSync[i] & maskReg[i];
  end

  for (genvar j = 0; j < NUM_CODE; j++) begin : g_codeGate
    assign codeFire[j] = codeHit[j] & maskReg[CODE_BASE+j];
  end

  assign secChange = armed & (secStatus ^ prevSec) & maskReg[SEC_BIT];

  always_comb begin
    hit.sync = |syncRise;
    hit.sec  = secChange;
    hit.code = |codeFire;
  end

  // Vector encoding driven by the control's one-hot selection
  always_comb begin
    irqVector = '0;
    if (sel.selSync)     irqVector = SYNC_VEC;
    else if (sel.selSec) irqVector = SEC_VEC;
    else if (sel.selCode) irqVector = CODE_VEC;
  end

  AST_MASK_LOAD: assert property (@(posedge clk) disable iff (!rstN)
    maskWr |=> (maskReg == $past(maskData))) else $error("mask load"); // R2

  AST_SEC_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    $stable(secStatus) |-> !hit.sec) else $error("sec quiet"); // R4

  AST_MASK_BLOCKS_SEC: assert property (@(posedge clk) disable iff (!rstN)
    !maskReg[SEC_BIT] |-> !hit.sec) else $error("sec masked"); // R2

endmodule

// File: rtl/frm_irq_ctl.sv
module frm_irq_ctl
  import frm_irq_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  grpHit_t hit,
  input  logic    ack,
  output vecSel_t sel,
  output logic    irqReq
);

  logic pendSync;
  logic pendSec;
  logic pendCode;

  // Fixed priority: sync/alarm, then one-second, then code detect
  always_comb begin
    sel.selSync = pendSync;
    sel.selSec  = pendSec & ~pendSync;
    sel.selCode = pendCode & ~pendSec & ~pendSync;
  end

  assign irqReq = pendSync | pendSec | pendCode;

  // Acknowledge clears only the presented group; a new hit wins over it
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendSync <= 1'b0;
      pendSec  <= 1'b0;
      pendCode <= 1'b0;
    end else begin
      pendSync <= hit.sync | (pendSync & ~(ack & sel.selSync));
      pendSec  <= hit.sec  | (pendSec  & ~(ack & sel.selSec));
      pendCode <= hit.code | (pendCode & ~(ack & sel.selCode));
    end
  end

  AST_PEND_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pendSync && !ack) |=> pendSync) else $error("pending dropped"); // R7

  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    (ack && sel.selSync && !hit.sync) |=> !pendSync) else $error("ack clear"); // R8

  AST_ACK_KEEPS_OTHERS: assert property (@(posedge clk) disable iff (!rstN)
    (ack && sel.selSync && pendSec) |=> pendSec) else $error("ack overreach"); // R8

  AST_SET_WINS: assert property (@(posedge clk) disable iff (!rstN)
    hit.code |=> pendCode) else $error("hit lost"); // R9

endmodule

// File: rtl/frm_irq_vector.sv
module frm_irq_vector
  import frm_irq_pkg::*;
#(
  parameter int NUM_SYNC = 4,
  parameter int NUM_CODE = 3,
  parameter int VEC_W = 8
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       maskWr,
  input  logic [NUM_SYNC+NUM_CODE:0] maskData,
  input  logic [NUM_SYNC-1:0]        syncLevel,
  input  logic                       secStatus,
  input  logic [NUM_CODE-1:0]        codeHit,
  input  logic                       ack,
  output logic                       irqReq,
  output logic [VEC_W-1:0]           irqVector
);

  grpHit_t grpHit;
  vecSel_t vecSel;

  frm_irq_dp #(
    .NUM_SYNC(NUM_SYNC),
    .NUM_CODE(NUM_CODE),
    .VEC_W(VEC_W)
  ) uDp (
    .clk(clk),
    .rstN(rstN),
    .maskWr(maskWr),
    .maskData(maskData),
    .syncLevel(syncLevel),
    .secStatus(secStatus),
    .codeHit(codeHit),
    .sel(vecSel),
    .hit(grpHit),
    .irqVector(irqVector)
  );

  frm_irq_ctl uCtl (
    .clk(clk),
    .rstN(rstN),
    .hit(grpHit),
    .ack(ack),
    .sel(vecSel),
    .irqReq(irqReq)
  );

  AST_REQ_MATCHES_VEC: assert property (@(posedge clk) disable iff (!rstN)
    irqReq == (irqVector != '0)) else $error("req/vector mismatch"); // R7

  AST_VEC_KNOWN: assert property (@(posedge clk) disable iff (!rstN)
    $countones(irqVector) <= 1) else $error("vector not a single code"); // R6

endmodule

// File: tb/frm_irq_vector_test.sv
module frm_irq_vector_test;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       maskWr = 1'b0;
  logic [7:0] maskData = '0;
  logic [3:0] syncLevel = '0;
  logic       secStatus = 1'b0;
  logic [2:0] codeHit = '0;
  logic       ack = 1'b0;
  logic       irqReq;
  logic [7:0] irqVector;

  int cyc = 0;
  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  typedef struct {
    int         due;
    logic       req;
    logic [7:0] vec;
    string      tag;
  } exp_t;

  exp_t q[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  frm_irq_vector uut (
    .clk(clk),
    .rstN(rstN),
    .maskWr(maskWr),
    .maskData(maskData),
    .syncLevel(syncLevel),
    .secStatus(secStatus),
    .codeHit(codeHit),
    .ack(ack),
    .irqReq(irqReq),
    .irqVector(irqVector)
  );

  // Driver: queue what the outputs must show after the next edge
  task automatic step(input logic eReq, input logic [7:0] eVec, input string tag);
    exp_t e;
    e.due = cyc + 1;
    e.req = eReq;
    e.vec = eVec;
    e.tag = tag;
    q.push_back(e);
    @(posedge clk);
    #1;
  endtask

  // Monitor: compare at the falling edge
  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= cyc) begin
      exp_t e;
      e = q.pop_front();
      checks++;
      if (irqReq !== e.req || irqVector !== e.vec) begin
        fails++;
        $display("FAIL %s: actual req=%0b vec=%02h expected req=%0b vec=%02h",
                 e.tag, irqReq, irqVector, e.req, e.vec);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL R7 watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    step(1'b0, 8'h00, "R1 in reset");
    rstN = 1'b1;
    step(1'b0, 8'h00, "R1 after release");

    // Everything masked out of reset
    syncLevel[0] = 1'b1; secStatus = 1'b1; codeHit = 3'b111;
    step(1'b0, 8'h00, "R2 all sources masked");
    codeHit = '0;

    maskWr = 1'b1; maskData = 8'hFF;
    step(1'b0, 8'h00, "R10 mask write");
    maskWr = 1'b0;
    step(1'b0, 8'h00, "R10 edge lost while masked");

    syncLevel[0] = 1'b0;
    step(1'b0, 8'h00, "R3 falling level ignored");

    syncLevel[1] = 1'b1;
    step(1'b1, 8'h80, "R3 CRC-4 loss rise");
    step(1'b1, 8'h80, "R7 held without ack");
    ack = 1'b1;
    step(1'b0, 8'h00, "R8 ack clears sync");
    ack = 1'b0;
    step(1'b0, 8'h00, "R3 one interrupt for held level");

    secStatus = 1'b0;
    step(1'b1, 8'h08, "R4 falling second");
    ack = 1'b1;
    step(1'b0, 8'h00, "R8 ack clears second");
    ack = 1'b0;
    secStatus = 1'b1;
    step(1'b1, 8'h08, "R4 rising second");

    codeHit = 3'b100;
    step(1'b1, 8'h08, "R6 second over code");
    codeHit = '0;
    syncLevel[2] = 1'b1;
    step(1'b1, 8'h80, "R6 sync over all");

    ack = 1'b1;
    step(1'b1, 8'h08, "R8 only sync cleared");
    step(1'b1, 8'h02, "R8 second cleared");
    step(1'b0, 8'h00, "R5 stop group cleared");
    ack = 1'b0;

    codeHit = 3'b001;
    step(1'b1, 8'h02, "R5 data hit");
    codeHit = 3'b010; ack = 1'b1;
    step(1'b1, 8'h02, "R9 start hit beats ack");
    codeHit = '0;
    step(1'b0, 8'h00, "R9 later ack clears");
    ack = 1'b0;

    // Selective masks
    maskWr = 1'b1; maskData = 8'hEF;
    step(1'b0, 8'h00, "R2 write sec-off mask");
    maskWr = 1'b0;
    secStatus = 1'b0;
    step(1'b0, 8'h00, "R2 second masked");
    maskWr = 1'b1; maskData = 8'h10;
    step(1'b0, 8'h00, "R2 write sec-only mask");
    maskWr = 1'b0;
    syncLevel[3] = 1'b1;
    step(1'b0, 8'h00, "R2 alarm masked");
    codeHit = 3'b111;
    step(1'b0, 8'h00, "R2 code masked");
    codeHit = '0;

    // Mask write on the same edge as a rising level
    maskWr = 1'b1; maskData = 8'h01; syncLevel[0] = 1'b1;
    step(1'b0, 8'h00, "R10 old mask applies");
    maskWr = 1'b0;
    step(1'b0, 8'h00, "R10 unmask does not recover edge");
    syncLevel[0] = 1'b0;
    step(1'b0, 8'h00, "R3 fall ignored");
    syncLevel[0] = 1'b1;
    step(1'b1, 8'h80, "R2 enabled source fires");
    ack = 1'b1;
    step(1'b0, 8'h00, "R8 final ack");
    step(1'b0, 8'h00, "R7 ack with nothing pending");
    ack = 1'b0;

    repeat (3) @(posedge clk);
    #1;
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule